// File: doc/BRIEF.md
# Asymmetric Block Map and Write-Lock Gate

This block sits beside the command engine of a 16-bit-wide, 524,288-word flash array. It turns a 19-bit word address into the index of the erase block that holds it. The array is split into blocks of unequal size: one 8K-word boot block, two 4K-word parameter blocks, one 16K-word block and fifteen 32K-word blocks, for 19 blocks in all. A parameter chooses whether the boot block sits at the bottom or at the top of the address space. In the top variant the block order is mirrored.

The block holds one lock bit per block, where 1 means unlocked. For each program or erase request it returns a registered allow or deny, one cycle later. A low protect input enforces the lock bits. A high protect input, or an asserted high-voltage override, lets every block be changed. Only in that bypassed state does a lock-set request lock a block, and only then does an erase-done pulse unlock the erased block again. The lock bits live in flops, and nonvolatile retention is handled elsewhere.

Top module: `bootblk_guard`

## Requirements
- R1: With `TOP_BOOT=0`, `blk_idx` decodes as follows: 0 for 00000h–01FFFh, 1 for 02000h–02FFFh, 2 for 03000h–03FFFh, 3 for 04000h–07FFFh, and 4+k for the k-th 32K-word block from 08000h, so 78000h–7FFFFh gives 18. `blk_idx` never exceeds 18.
- R2: With `TOP_BOOT=1` the map is mirrored: `blk_idx(a)` equals 18 minus the bottom-variant index of (7FFFFh − a). Index 18 is the boot block at 7E000h–7FFFFh, and index 0 is 00000h–07FFFh.
- R3: After reset every lock bit is 1, so every request is allowed.
- R4: A `lock_set` pulse clears the addressed block's lock bit to 0 when bypass is active (`wp_n`=1 or `hv_ovr`=1). Without bypass it has no effect.
- R5: A request to a block whose lock bit is 0 is denied (`rsp_allow`=0) when `wp_n`=0 and `hv_ovr`=0.
- R6: When `wp_n`=1 or `hv_ovr`=1, every request is allowed whatever the lock bit.
- R7: An `erase_done` pulse sets the addressed block's lock bit to 1 when bypass is active, and has no effect otherwise. If `erase_done` and `lock_set` both arrive in one cycle, `erase_done` wins.
- R8: The response is registered. `rsp_valid` is 1 exactly one cycle after a cycle with `req_valid`=1. `rsp_erase` echoes `req_erase`. The decision uses the lock bits as they stood before any update made in that same request cycle.
- R9: `rsp_valid` and `rsp_allow` are 0 in the cycle after a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 19 | Word address of the request or lock update |
| req_valid | input | 1 | A program or erase request is presented |
| req_erase | input | 1 | 1 = erase, 0 = program |
| wp_n | input | 1 | Protect input; low enforces lock bits |
| hv_ovr | input | 1 | High-voltage override; bypasses lock bits |
| erase_done | input | 1 | Successful erase of the addressed block |
| lock_set | input | 1 | Request to lock the addressed block |
| blk_idx | output | 5 | Block index of `addr` (combinational) |
| rsp_valid | output | 1 | Registered response strobe |
| rsp_allow | output | 1 | 1 = operation may proceed |
| rsp_erase | output | 1 | Operation type of the answered request |

## Verification
The in-RTL properties check on every cycle that the index stays in range, that reset leaves all blocks unlocked, that the count of unlocked blocks can fall only through a bypassed lock-set and rise only through a bypassed erase-done, and that a protected, locked request is answered with a deny on the next cycle. Whether the right block was hit, the exact range boundaries of both the bottom and mirrored maps, and the same-cycle priority of erase-done over lock-set need the bench's reference model. That model is driven by directed edge addresses and by a seeded random mix of requests and lock updates.

// File: rtl/bootblk_pkg.sv
package bootblk_pkg;
    localparam int ADDR_W   = 19;
    localparam int NUM_BLK  = 19;
    localparam int BLK_W    = $clog2(NUM_BLK);
    localparam int BIG_LSB  = 15;               // 32K-word blocks
    localparam int MID_BIT  = 14;               // 16K-word block
    localparam int PAR_BIT  = 13;               // parameter pair region
    localparam int PSEL_BIT = 12;               // selects between parameter blocks
    localparam int BIG_BASE = 3;                // index offset of first 32K block minus one
    localparam logic [BLK_W-1:0] LAST_IDX = BLK_W'(NUM_BLK - 1);

    typedef logic [ADDR_W-1:0] waddr_t;
    typedef logic [BLK_W-1:0]  bidx_t;

    typedef enum logic { OP_PROG = 1'b0, OP_ERASE = 1'b1 } op_e;

    typedef struct packed {
        logic valid;
        logic allow;
        op_e  op;
    } rsp_t;

    // index for the bottom-boot arrangement
    function automatic bidx_t bottom_idx(input waddr_t a);
        bidx_t r;
        if (a[ADDR_W-1:BIG_LSB] != '0)
            r = BLK_W'(a[ADDR_W-1:BIG_LSB]) + BLK_W'(BIG_BASE);
        else if (a[MID_BIT])
            r = BLK_W'(3);
        else if (a[PAR_BIT])
            r = a[PSEL_BIT] ? BLK_W'(2) : BLK_W'(1);
        else
            r = '0;
        return r;
    endfunction

    function automatic bidx_t map_idx(input waddr_t a, input bit top);
        return top ? (LAST_IDX - bottom_idx(~a)) : bottom_idx(a);
    endfunction
endpackage

// File: rtl/bootblk_decode.sv
module bootblk_decode
    import bootblk_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  waddr_t addr_i,
    output bidx_t  idx_o
);
    always_comb idx_o = map_idx(addr_i, TOP_BOOT);

    assert_idx_range_R1: assert property (@(posedge clk) disable iff (rst)
        idx_o <= LAST_IDX);
endmodule

// File: rtl/bootblk_lockbank.sv
module bootblk_lockbank
    import bootblk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bidx_t              idx_i,
    input  logic               bypass_i,
    input  logic               erase_done_i,
    input  logic               lock_set_i,
    output logic [NUM_BLK-1:0] unlocked_o
);
    generate
        for (genvar i = 0; i < NUM_BLK; i++) begin : g_bit
            logic hit;
            assign hit = (idx_i == BLK_W'(i)) && bypass_i;
            always_ff @(posedge clk) begin
                if (rst)
                    unlocked_o[i] <= 1'b1;
                else if (hit && erase_done_i)
                    unlocked_o[i] <= 1'b1;
                else if (hit && lock_set_i)
                    unlocked_o[i] <= 1'b0;
            end
        end
    endgenerate

    assert_reset_open_R3: assert property (@(posedge clk)
        rst |=> (unlocked_o == {NUM_BLK{1'b1}}));

    assert_lock_only_bypassed_R4: assert property (@(posedge clk) disable iff (rst)
        !(lock_set_i && bypass_i) |=>
            ($countones(unlocked_o) >= $countones($past(unlocked_o))));

    assert_unlock_only_bypassed_R7: assert property (@(posedge clk) disable iff (rst)
        !(erase_done_i && bypass_i) |=>
            ($countones(unlocked_o) <= $countones($past(unlocked_o))));
endmodule

// File: rtl/bootblk_gate.sv
module bootblk_gate
    import bootblk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid_i,
    input  op_e  req_op_i,
    input  logic bypass_i,
    input  logic unlocked_i,
    output rsp_t rsp_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_o <= '{valid: 1'b0, allow: 1'b0, op: OP_PROG};
        end else begin
            rsp_o.valid <= req_valid_i;
            rsp_o.allow <= req_valid_i && (bypass_i || unlocked_i);
            rsp_o.op    <= req_op_i;
        end
    end

    assert_deny_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !bypass_i && !unlocked_i) |=> (rsp_o.valid && !rsp_o.allow));

    assert_bypass_allows_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && bypass_i) |=> rsp_o.allow);

    assert_resp_follows_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> rsp_o.valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> (!rsp_o.valid && !rsp_o.allow));
endmodule

// File: rtl/bootblk_guard.sv
module bootblk_guard
    import bootblk_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [18:0] addr,
    input  logic        req_valid,
    input  logic        req_erase,
    input  logic        wp_n,
    input  logic        hv_ovr,
    input  logic        erase_done,
    input  logic        lock_set,
    output logic [4:0]  blk_idx,
    output logic        rsp_valid,
    output logic        rsp_allow,
    output logic        rsp_erase
);
    bidx_t              idx;
    logic               bypass;
    logic [NUM_BLK-1:0] unlocked;
    rsp_t               rsp;
    op_e                op;

    assign bypass = wp_n | hv_ovr;
    assign op     = req_erase ? OP_ERASE : OP_PROG;

    bootblk_decode #(.TOP_BOOT(TOP_BOOT)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .addr_i (addr),
        .idx_o  (idx)
    );

    bootblk_lockbank u_lock (
        .clk          (clk),
        .rst          (rst),
        .idx_i        (idx),
        .bypass_i     (bypass),
        .erase_done_i (erase_done),
        .lock_set_i   (lock_set),
        .unlocked_o   (unlocked)
    );

    bootblk_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (req_valid),
        .req_op_i    (op),
        .bypass_i    (bypass),
        .unlocked_i  (unlocked[idx]),
        .rsp_o       (rsp)
    );

    assign blk_idx   = idx;
    assign rsp_valid = rsp.valid;
    assign rsp_allow = rsp.allow;
    assign rsp_erase = (rsp.op == OP_ERASE);
endmodule

// File: tb/sim_bootblk_guard.sv
module sim_bootblk_guard;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [18:0] addr = '0;
    logic req_valid = 0, req_erase = 0, wp_n = 0, hv_ovr = 0, erase_done = 0, lock_set = 0;
    logic [4:0] blk_idx, blk_idx_t;
    logic rsp_valid, rsp_allow, rsp_erase;
    logic rv_t, ra_t, re_t;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    bit model_open [19];

    always #10 clk = ~clk;   // 50 MHz

    bootblk_guard #(.TOP_BOOT(1'b0)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .req_valid(req_valid), .req_erase(req_erase),
        .wp_n(wp_n), .hv_ovr(hv_ovr), .erase_done(erase_done), .lock_set(lock_set),
        .blk_idx(blk_idx), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_erase(rsp_erase));

    bootblk_guard #(.TOP_BOOT(1'b1)) u1 (
        .clk(clk), .rst(rst), .addr(addr), .req_valid(1'b0), .req_erase(1'b0),
        .wp_n(1'b0), .hv_ovr(1'b0), .erase_done(1'b0), .lock_set(1'b0),
        .blk_idx(blk_idx_t), .rsp_valid(rv_t), .rsp_allow(ra_t), .rsp_erase(re_t));

    function automatic int ref_bottom(input int a);
        if (a < 'h2000) return 0;
        if (a < 'h3000) return 1;
        if (a < 'h4000) return 2;
        if (a < 'h8000) return 3;
        return 4 + (a - 'h8000) / 'h8000;
    endfunction

    function automatic int ref_top(input int a);
        return 18 - ref_bottom('h7FFFF - a);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // inputs are applied right after a falling edge; response is checked one full cycle later
    task automatic step(input int a, input bit rq, input bit er, input bit wp, input bit ov,
                        input bit ed, input bit ls, input string tag);
        int  b;
        bit  byp;
        bit  exp_allow;
        addr = 19'(a); req_valid = rq; req_erase = er; wp_n = wp; hv_ovr = ov;
        erase_done = ed; lock_set = ls;
        #1;
        b = ref_bottom(a);
        check({tag, " R1 bottom index"}, int'(blk_idx), b);
        check({tag, " R2 top index"}, int'(blk_idx_t), ref_top(a));
        byp = wp | ov;
        exp_allow = rq && (byp || model_open[b]);
        if (ed && byp) model_open[b] = 1;
        else if (ls && byp) model_open[b] = 0;
        @(posedge clk);
        @(negedge clk);
        check({tag, " R8/R9 rsp_valid"}, int'(rsp_valid), int'(rq));
        check({tag, " R5/R6 rsp_allow"}, int'(rsp_allow), int'(exp_allow));
        if (rq) check({tag, " R8 rsp_erase"}, int'(rsp_erase), int'(er));
    endtask

    function automatic int blk_base(input int b);
        if (b == 0) return 0;
        if (b == 1) return 'h2000;
        if (b == 2) return 'h3000;
        if (b == 3) return 'h4000;
        return 'h8000 * (b - 3);
    endfunction

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int seed;
        int edges [10];
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        for (int i = 0; i < 19; i++) model_open[i] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R3: reset leaves every block open even while protected
        check("R3 rsp_valid after reset", int'(rsp_valid), 0);
        for (int b = 0; b < 19; b++) step(blk_base(b), 1, 0, 0, 0, 0, 0, "R3 open");
        // R1/R2 boundaries
        edges = '{0, 'h1FFF, 'h2000, 'h2FFF, 'h3000, 'h3FFF, 'h4000, 'h7FFF, 'h8000, 'h7FFFF};
        foreach (edges[i]) step(edges[i], 0, 0, 0, 0, 0, 0, "R1 edge");
        step('h7E000, 0, 0, 0, 0, 0, 0, "R2 edge");
        step('h7DFFF, 0, 0, 0, 0, 0, 0, "R2 edge");
        // R4: lock without bypass ignored, then with bypass honoured
        step('h2100, 0, 0, 0, 0, 0, 1, "R4 lock ignored");
        step('h2100, 1, 1, 0, 0, 0, 0, "R4 still open");
        step('h0010, 0, 0, 1, 0, 0, 1, "R4 lock via wp_n");
        step('h0010, 1, 0, 0, 0, 0, 0, "R5 deny locked");
        step('h0010, 1, 1, 0, 1, 0, 0, "R6 override allows");
        step('h0010, 1, 0, 1, 0, 0, 0, "R6 wp_n allows");
        // R7: erase without bypass leaves it locked; with bypass unlocks
        step('h0010, 0, 0, 0, 0, 1, 0, "R7 erase ignored");
        step('h0010, 1, 0, 0, 0, 0, 0, "R7 still locked");
        step('h0010, 0, 0, 0, 1, 1, 0, "R7 erase unlocks");
        step('h0010, 1, 0, 0, 0, 0, 0, "R7 reopened");
        // R7 priority, R8 same-cycle update not seen by the request
        step('h40000, 0, 0, 0, 1, 0, 1, "R7 lock big");
        step('h40000, 1, 0, 0, 1, 1, 1, "R7 both same cycle");
        step('h40000, 1, 0, 0, 0, 0, 0, "R7 erase won");
        step('h7FFFF, 1, 1, 1, 0, 0, 1, "R8 lock same cycle");
        step('h7FFFF, 1, 1, 0, 0, 0, 0, "R8 locked next");
        // random mix
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom);
            step(int'($urandom % 32'h80000), r[0], r[1], r[4:2] == 3'd0, r[7:5] == 3'd0,
                 r[10:8] == 3'd0, r[13:11] < 3'd2, "rand");
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule